// File: doc/BRIEF.md
# Quad Lane Swizzle Crossbar

This block reorders per-lane data inside every aligned group of four neighbouring lanes of a wide subgroup. A single 8-bit selector word holds four 2-bit fields. Field k names which lane of the quad feeds output position k. The same four fields steer every quad in the subgroup, so one selector word describes a single permutation or broadcast pattern that repeats across all quads. Data never moves from one quad to another.

Each source lane is gated by its own active bit. When an output position selects an inactive lane, that position returns zero and not whatever value the inactive lane happens to carry. The active state of the destination lane plays no part. The crossbar has one register stage. A result appears together with its valid strobe one clock after the input strobe, and the output holds its value between strobes.

Top module: `quad_swizzle`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R3: For lane index i, let base be i with its two low bits cleared and k = i mod 4. If source lane base + `in_sel[2k+1:2k]` is active, output lane i carries the data of that source lane. Lane i occupies bits [i*DW+DW-1 : i*DW] of both data buses.
- R4: If source lane base + `in_sel[2k+1:2k]` is inactive (its bit in `in_active` is 0), output lane i is zero.
- R5: The active bit of the destination lane i has no effect on output lane i. Only the selected source lane's bit matters.
- R6: No output lane ever depends on data or active bits of a lane outside its own quad.
- R7: In a cycle after `in_valid` is low, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| in_data | input | LANES*DW | Flattened lane data, lane 0 in the low bits |
| in_active | input | LANES | Per-lane active bits |
| in_sel | input | 8 | Four 2-bit source selectors, field k in bits [2k+1:2k] |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | LANES*DW | Flattened swizzled lane data |

## Verification
The hardest case to reach from the ports is an active destination lane whose selected source is inactive. Its opposite is also hard: an inactive destination lane that still receives data from an active source. Both must appear in the same quad, under the same selector, so that R4 and R5 are told apart. The stimulus therefore combines broadcast selectors with sparse active masks (one lane per quad, or a single quad alive). Randomised masks and selectors are then added on top. Distinct per-lane data makes any cross-quad leak or wrong field show up at once.

// File: rtl/quad_swizzle.sv
module quad_swizzle #(
  parameter int LANES = 64,
  parameter int DW    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [LANES*DW-1:0]   in_data,
  input  logic [LANES-1:0]      in_active,
  input  logic [7:0]            in_sel,
  output logic                  out_valid,
  output logic [LANES*DW-1:0]   out_data
);

  localparam int QUADS = LANES / 4;

  logic [LANES*DW-1:0] swz;

  for (genvar q = 0; q < QUADS; q++) begin : g_quad
    logic [4*DW-1:0] qd;
    logic [3:0]      qa;
    assign qd = in_data[q*4*DW +: 4*DW];
    assign qa = in_active[q*4 +: 4];
    for (genvar k = 0; k < 4; k++) begin : g_pos
      logic [1:0] s;
      assign s = in_sel[2*k +: 2];
      assign swz[(q*4+k)*DW +: DW] = qa[s] ? qd[s*DW +: DW] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= swz;
    end
  end

endmodule

// File: rtl/quad_swizzle_chk.sv
module quad_swizzle_chk #(
  parameter int LANES = 64,
  parameter int DW    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [LANES*DW-1:0] in_data,
  input logic [LANES-1:0]    in_active,
  input logic [7:0]          in_sel,
  input logic                out_valid,
  input logic [LANES*DW-1:0] out_data
);

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_data == '0));

  assert_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int K    = i % 4;
    localparam int BASE = i - K;

    // R3 and R6: the selected lane stays inside the quad and its data arrives
    assert_src_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_active[BASE + int'(in_sel[2*K +: 2])])
      |=> out_data[i*DW +: DW] == $past(in_data[(BASE + int'(in_sel[2*K +: 2]))*DW +: DW]));

    assert_src_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_active[BASE + int'(in_sel[2*K +: 2])])
      |=> out_data[i*DW +: DW] == '0);
  end

endmodule

bind quad_swizzle quad_swizzle_chk #(.LANES(LANES), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_active(in_active), .in_sel(in_sel), .out_valid(out_valid),
  .out_data(out_data)
);

// File: tb/quad_swizzle_tb_top.sv
`timescale 1ns/1ps
module quad_swizzle_tb_top;
  localparam int LANES = 64;
  localparam int DW    = 32;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic [LANES*DW-1:0] in_data = '0;
  logic [LANES-1:0]    in_active = '0;
  logic [7:0]          in_sel = '0;
  logic                out_valid;
  logic [LANES*DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [LANES*DW-1:0] exp_q[$];
  string               tag_q[$];
  logic [LANES*DW-1:0] last_out = '0;
  bit                  have_last = 0;

  always #4 clk = ~clk;

  quad_swizzle #(.LANES(LANES), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_active(in_active), .in_sel(in_sel), .out_valid(out_valid),
    .out_data(out_data)
  );

  function automatic logic [LANES*DW-1:0] model(input logic [LANES*DW-1:0] d,
                                                 input logic [LANES-1:0] a,
                                                 input logic [7:0] s);
    logic [LANES*DW-1:0] r;
    r = '0;
    for (int i = 0; i < LANES; i++) begin
      int src;
      src = (i / 4) * 4 + int'(s[2*(i%4) +: 2]);
      r[i*DW +: DW] = a[src] ? d[src*DW +: DW] : '0;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [LANES*DW-1:0] act,
                       input logic [LANES*DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [LANES*DW-1:0] d, input logic [LANES-1:0] a,
                      input logic [7:0] s, input string tag);
    @(negedge clk);
    in_valid  = 1'b1;
    in_data   = d;
    in_active = a;
    in_sel    = s;
    exp_q.push_back(model(d, a, s));
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid  = 1'b0;
    in_data   = ~d;
    in_active = ~a;
    in_sel    = ~s;
  endtask

  function automatic logic [LANES*DW-1:0] lane_ids(input logic [15:0] salt);
    logic [LANES*DW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*DW +: DW] = {salt, 8'hA0, 8'(i + 1)};
    return r;
  endfunction

  function automatic logic [LANES*DW-1:0] rand_data();
    logic [LANES*DW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*DW +: DW] = DW'($urandom);
    return r;
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected out_valid", out_data, '0);
        end else begin
          logic [LANES*DW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data === e, t, out_data, e);
        end
        last_out  = out_data;
        have_last = 1;
      end else if (have_last) begin
        check(out_data === last_out, "R7 hold while idle", out_data, last_out);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 reset valid", {{(LANES*DW-1){1'b0}}, out_valid}, '0);
    check(out_data === '0, "R1 reset data", out_data, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 identity and full reversal, all lanes active
    send(lane_ids(16'h1111), '1, 8'b11_10_01_00, "R3 identity");
    send(lane_ids(16'h2222), '1, 8'b00_01_10_11, "R3 reverse");
    send(lane_ids(16'h3333), '1, 8'b10_11_00_01, "R3 pair swap");
    // R4 broadcast of a lane that is inactive in every quad
    send(lane_ids(16'h4444), {QUAD_REP(4'b1101)}, 8'b01_01_01_01, "R4 inactive source zero");
    // R5 only lane 0 of each quad active, broadcast lane 0
    send(lane_ids(16'h5555), {QUAD_REP(4'b0001)}, 8'b00_00_00_00, "R5 inactive destination");
    // R6 single quad alive
    send(lane_ids(16'h6666), {{(LANES-8){1'b0}}, 4'b1111, 4'b0000}, 8'b11_00_10_01, "R6 quad isolation");
    repeat (3) @(negedge clk);
    // back-to-back strobes
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_data   = rand_data();
      in_active = {$urandom, $urandom};
      in_sel    = 8'($urandom);
      exp_q.push_back(model(in_data, in_active, in_sel));
      tag_q.push_back("R3 R4 back-to-back random");
    end
    @(negedge clk);
    in_valid = 1'b0;
    for (int n = 0; n < 30; n++)
      send(rand_data(), {$urandom, $urandom}, 8'($urandom), "R3 R4 R5 random");
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all results delivered", LANES*DW'(exp_q.size()), '0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [LANES-1:0] QUAD_REP(input logic [3:0] p);
    logic [LANES-1:0] r;
    for (int q = 0; q < LANES / 4; q++) r[q*4 +: 4] = p;
    return r;
  endfunction

endmodule